// File: doc/BRIEF.md
# ATM Cell Receive PHY Slave

This block is the PHY-side end of a polled, multi-PHY, byte-wide cell bus. It faces the ATM layer and sends cells toward it. Logic inside the chip loads complete 53-byte cells, one byte per cycle, through a write port into a small buffer of cell slots. A full flag refuses further bytes when every slot holds a finished cell that has not been sent.

The ATM layer polls the bus by putting a PHY address on the poll lines. In the cycle after its own receive-side address is seen, the block drives its cell-available line. That line is high only if a complete cell is buffered. The ATM layer then pulls the active-low read enable. In each cycle after an enabled cycle, the block drives the data bus and the start-of-cell flag, and the ATM layer takes them at the end of that cycle.

The byte index moves forward only on those driven cycles. A gap in the enable holds the index where it is. After the 53rd byte has gone out, the slot is freed. The tri-state drivers sit in the pad ring, so every three-state output comes out as a value and an enable.

Top module: `cellrx_phy_slave`

## Requirements
- R1: After reset, rx_data_oe, rx_clav_oe, rx_clav, rx_soc and wr_full are all low and rx_data is zero.
- R2: rx_data_oe is high in a cycle exactly when rx_enb_n was low in the previous cycle.
- R3: rx_clav_oe is high in a cycle exactly when poll_addr equalled the receive-side address RX_PHY_ADDR in the previous cycle, and is low for every other address value.
- R4: When rx_clav_oe is high, rx_clav is high only if at least one cell has been fully written (all 53 bytes) and not yet fully sent. A partly written cell leaves rx_clav low.
- R5: On driven cycles, a buffered cell comes out as bytes 0 to 52, in the order they were written, on rx_data[7:0] (bit 7 most significant). rx_soc is high together with byte 0 only.
- R6: A cycle with rx_data_oe low does not advance the byte index. After a pause in mid-cell, output resumes at the byte that follows the last one driven.
- R7: After byte 52 of a cell has been driven, its slot is freed. The next driven cycle presents byte 0 of the next buffered cell with rx_soc high, or no cell if none is held.
- R8: wr_full is high exactly when all NUM_SLOTS slots hold complete unsent cells. A byte written while wr_full is high is dropped and does not appear in any later cell.
- R9: A driven cycle with no complete cell buffered puts zero on rx_data, keeps rx_soc low and consumes nothing.
- R10: When rx_data_oe is low, rx_data is zero and rx_soc is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Internal write strobe: one cell byte per cycle |
| wr_data | input | DATA_W | Cell byte being loaded |
| wr_full | output | 1 | High when every slot holds a complete unsent cell |
| rx_enb_n | input | 1 | Active-low read enable from the ATM layer |
| rx_data | output | DATA_W | Cell byte toward the ATM layer |
| rx_data_oe | output | 1 | Output enable for rx_data and rx_soc |
| rx_soc | output | 1 | Start-of-cell flag, high with byte 0 |
| poll_addr | input | ADDR_W | Poll and select address from the ATM layer |
| rx_clav | output | 1 | Cell-available value |
| rx_clav_oe | output | 1 | Output enable for rx_clav |

## Verification
The hardest state to reach is the one where reading and writing overlap at a slot boundary. A cell's last byte leaves on the same edge that another cell is committed, while the refused bytes of a full buffer are still pending. To get there, the stimulus fills both slots and keeps writing into the full buffer. It then reads both cells back to back, and later streams writes and reads in the same cycles. A bench model counts commits and frees per edge, so every byte, flag and enable is predicted cycle by cycle.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

   // Slot pointer advance with wrap, usable for any slot count.
   function automatic int unsigned slot_next(input int unsigned cur, input int unsigned slots);
      return (cur == slots - 1) ? 0 : cur + 1;
   endfunction

   // Width that holds values 0..n-1, never below one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cellrx_store.sv
module cellrx_store
   import cellrx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int NUM_SLOTS  = 2,
   localparam int IDX_W     = idx_width(CELL_BYTES),
   localparam int SLOT_W    = idx_width(NUM_SLOTS),
   localparam int CNT_W     = idx_width(NUM_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic [SLOT_W-1:0] rd_slot,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_free,
   output logic              cells_ready,
   output logic [DATA_W-1:0] rd_byte
);

   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_BYTES - 1);
   localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(NUM_SLOTS);
   localparam bit               SLOT_POW2 = (NUM_SLOTS & (NUM_SLOTS - 1)) == 0;

   logic [IDX_W-1:0]  wr_idx;
   logic [SLOT_W-1:0] wr_slot;
   logic [SLOT_W-1:0] wr_slot_nx;
   logic [CNT_W-1:0]  cell_cnt;
   logic              wr_take;
   logic              wr_commit;
   logic [DATA_W-1:0] slot_rd [NUM_SLOTS];

   assign wr_full     = (cell_cnt == CNT_FULL);
   assign wr_take     = wr_en && !wr_full;
   assign wr_commit   = wr_take && (wr_idx == LAST_IDX);
   assign cells_ready = (cell_cnt != '0);

   generate
      if (SLOT_POW2) begin : g_ptr_pow2
         assign wr_slot_nx = wr_slot + SLOT_W'(1);
      end else begin : g_ptr_wrap
         assign wr_slot_nx = SLOT_W'(slot_next(int'(wr_slot), NUM_SLOTS));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_idx   <= '0;
         wr_slot  <= '0;
         cell_cnt <= '0;
      end else begin
         if (wr_take) begin
            if (wr_commit) begin
               wr_idx  <= '0;
               wr_slot <= wr_slot_nx;
            end else begin
               wr_idx <= wr_idx + IDX_W'(1);
            end
         end
         case ({wr_commit, rd_free})
            2'b10:   cell_cnt <= cell_cnt + CNT_W'(1);
            2'b01:   cell_cnt <= cell_cnt - CNT_W'(1);
            default: cell_cnt <= cell_cnt;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic [DATA_W-1:0] cell_mem [CELL_BYTES];
      always_ff @(posedge clk) begin
         if (wr_take && (wr_slot == SLOT_W'(g))) begin
            cell_mem[wr_idx] <= wr_data;
         end
      end
      assign slot_rd[g] = cell_mem[rd_idx];
   end

   assign rd_byte = slot_rd[rd_slot];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cell_cnt <= CNT_FULL); // R8
   AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_full) |=> $stable(wr_idx)); // R8
   AST_FREE_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_free |-> cells_ready); // R7

endmodule

// File: rtl/cellrx_reader.sv
module cellrx_reader
   import cellrx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int NUM_SLOTS  = 2,
   localparam int IDX_W     = idx_width(CELL_BYTES),
   localparam int SLOT_W    = idx_width(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enb_n,
   input  logic              cells_ready,
   input  logic [DATA_W-1:0] rd_byte,
   output logic [SLOT_W-1:0] rd_slot,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              rd_free,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_data_oe,
   output logic              rx_soc
);

   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_BYTES - 1);
   localparam bit               SLOT_POW2 = (NUM_SLOTS & (NUM_SLOTS - 1)) == 0;

   logic              en_q;
   logic              beat;
   logic [SLOT_W-1:0] rd_slot_nx;

   assign beat       = en_q && cells_ready;
   assign rd_free    = beat && (rd_idx == LAST_IDX);
   assign rx_data_oe = en_q;
   assign rx_soc     = beat && (rd_idx == '0);
   assign rx_data    = beat ? rd_byte : '0;

   generate
      if (SLOT_POW2) begin : g_ptr_pow2
         assign rd_slot_nx = rd_slot + SLOT_W'(1);
      end else begin : g_ptr_wrap
         assign rd_slot_nx = SLOT_W'(slot_next(int'(rd_slot), NUM_SLOTS));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         rd_idx  <= '0;
         rd_slot <= '0;
      end else begin
         en_q <= !rx_enb_n;
         if (rd_free) begin
            rd_idx  <= '0;
            rd_slot <= rd_slot_nx;
         end else if (beat) begin
            rd_idx <= rd_idx + IDX_W'(1);
         end
      end
   end

   AST_OE_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enb_n |=> rx_data_oe); // R2
   AST_OE_OFF_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_enb_n |=> !rx_data_oe); // R2
   AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_data_oe |=> $stable(rd_idx)); // R6
   AST_SOC_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      rx_soc |-> (rx_data_oe && cells_ready)); // R5
   AST_QUIET_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_data_oe |-> (rx_data == '0 && !rx_soc)); // R10

endmodule

// File: rtl/cellrx_poll.sv
module cellrx_poll #(
   parameter int          ADDR_W      = 5,
   parameter logic [ADDR_W-1:0] RX_PHY_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] poll_addr,
   input  logic              cells_ready,
   output logic              rx_clav,
   output logic              rx_clav_oe
);

   logic polled_q;

   always_ff @(posedge clk) begin
      if (!rst_n) polled_q <= 1'b0;
      else        polled_q <= (poll_addr == RX_PHY_ADDR);
   end

   assign rx_clav_oe = polled_q;
   assign rx_clav    = polled_q && cells_ready;

   AST_CLAV_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_addr == RX_PHY_ADDR) |=> rx_clav_oe); // R3
   AST_CLAV_OFF_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_addr != RX_PHY_ADDR) |=> !rx_clav_oe); // R3
   AST_CLAV_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clav |-> (rx_clav_oe && cells_ready)); // R4

endmodule

// File: rtl/cellrx_phy_slave.sv
module cellrx_phy_slave
   import cellrx_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          CELL_BYTES  = 53,
   parameter int          NUM_SLOTS   = 2,
   parameter int          ADDR_W      = 5,
   parameter logic [ADDR_W-1:0] RX_PHY_ADDR = 5'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rx_enb_n,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_data_oe,
   output logic              rx_soc,
   input  logic [ADDR_W-1:0] poll_addr,
   output logic              rx_clav,
   output logic              rx_clav_oe
);

   localparam int IDX_W  = idx_width(CELL_BYTES);
   localparam int SLOT_W = idx_width(NUM_SLOTS);

   generate
      if (CELL_BYTES < 2) begin : g_bad_cell
         $error("CELL_BYTES must be at least 2");
      end
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("NUM_SLOTS must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic              cells_ready;
   logic              rd_free;
   logic [SLOT_W-1:0] rd_slot;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_byte;

   cellrx_store #(
      .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .NUM_SLOTS(NUM_SLOTS)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
      .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_free(rd_free),
      .cells_ready(cells_ready), .rd_byte(rd_byte)
   );

   cellrx_reader #(
      .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .NUM_SLOTS(NUM_SLOTS)
   ) u_reader (
      .clk(clk), .rst_n(rst_n),
      .rx_enb_n(rx_enb_n), .cells_ready(cells_ready), .rd_byte(rd_byte),
      .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_free(rd_free),
      .rx_data(rx_data), .rx_data_oe(rx_data_oe), .rx_soc(rx_soc)
   );

   cellrx_poll #(
      .ADDR_W(ADDR_W), .RX_PHY_ADDR(RX_PHY_ADDR)
   ) u_poll (
      .clk(clk), .rst_n(rst_n),
      .poll_addr(poll_addr), .cells_ready(cells_ready),
      .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe)
   );

endmodule

// File: tb/cellrx_phy_slave_tb.sv
module cellrx_phy_slave_tb;

   localparam int CLK_P = 10;
   localparam int CB    = 53;
   localparam int NS    = 2;
   localparam logic [4:0] ADDR = 5'd3;
   localparam logic [4:0] NP   = 5'h1F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_full;
   logic       rx_enb_n = 1'b1;
   logic [7:0] rx_data;
   logic       rx_data_oe;
   logic       rx_soc;
   logic [4:0] poll_addr = NP;
   logic       rx_clav;
   logic       rx_clav_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string cur_tag = "R5";

   int m_cnt = 0, m_ridx = 0, m_rcell = 0, m_widx = 0, m_wcell = 0;
   bit prev_en = 1'b0;

   cellrx_phy_slave #(.RX_PHY_ADDR(ADDR)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
      .rx_enb_n(rx_enb_n), .rx_data(rx_data), .rx_data_oe(rx_data_oe), .rx_soc(rx_soc),
      .poll_addr(poll_addr), .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [7:0] pat(input int c, input int b);
      logic [7:0] v;
      v = 8'((c * 37 + b * 5 + 11) & 255);
      if (b == 0) v = v ^ 8'h80;
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input bit en, input bit wr, input logic [4:0] pa);
      bit full_b;
      int inc, dec;
      rx_enb_n  = !en;
      wr_en     = wr;
      wr_data   = wr ? pat(m_wcell, m_widx) : 8'h00;
      poll_addr = pa;
      @(posedge clk);
      full_b = (m_cnt == NS);
      inc = 0; dec = 0;
      if (prev_en && m_cnt > 0) begin
         if (m_ridx == CB - 1) begin m_ridx = 0; m_rcell++; dec = 1; end
         else m_ridx++;
      end
      if (wr && !full_b) begin
         if (m_widx == CB - 1) begin m_widx = 0; m_wcell++; inc = 1; end
         else m_widx++;
      end
      m_cnt = m_cnt + inc - dec;
      @(negedge clk);
      chk(rx_data_oe == en, "R2 data_oe", int'(rx_data_oe), int'(en));
      if (en && m_cnt > 0) begin
         chk(rx_data == pat(m_rcell, m_ridx), cur_tag, int'(rx_data), int'(pat(m_rcell, m_ridx)));
         chk(rx_soc == (m_ridx == 0), "R5 soc", int'(rx_soc), int'(m_ridx == 0));
      end else if (en) begin
         chk(rx_data == 8'h00 && !rx_soc, "R9 empty read", int'({rx_soc, rx_data}), 0);
      end else begin
         chk(rx_data == 8'h00 && !rx_soc, "R10 idle outputs", int'({rx_soc, rx_data}), 0);
      end
      chk(rx_clav_oe == (pa == ADDR), "R3 clav_oe", int'(rx_clav_oe), int'(pa == ADDR));
      chk(rx_clav == (pa == ADDR && m_cnt > 0), "R4 clav", int'(rx_clav), int'(pa == ADDR && m_cnt > 0));
      chk(wr_full == (m_cnt == NS), "R8 full", int'(wr_full), int'(m_cnt == NS));
      prev_en = en;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(!rx_data_oe && !rx_clav_oe && !rx_clav && !rx_soc && !wr_full && rx_data == 0,
          "R1 reset", int'({rx_data_oe, rx_clav_oe, rx_clav, rx_soc, wr_full}), 0);

      // R3: every poll address, empty buffer (R4 clav low)
      for (int a = 0; a < 32; a++) step(1'b0, 1'b0, 5'(a));

      // R9: enable with nothing buffered
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, ADDR);

      // R4: partial cell keeps clav low, completion raises it
      for (int i = 0; i < 30; i++) step(1'b0, 1'b1, NP);
      step(1'b0, 1'b0, ADDR);
      for (int i = 0; i < 23; i++) step(1'b0, 1'b1, NP);
      step(1'b0, 1'b0, ADDR);

      // R5 then R6: read 20 bytes, pause, resume
      cur_tag = "R5 byte order";
      for (int i = 0; i < 20; i++) step(1'b1, 1'b0, NP);
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, ADDR);
      cur_tag = "R6 resume byte";
      for (int i = 0; i < 33; i++) step(1'b1, 1'b0, NP);
      step(1'b0, 1'b0, ADDR);   // R7: slot freed, clav low

      // R8: fill both slots, refused writes while full
      for (int i = 0; i < 2 * CB; i++) step(1'b0, 1'b1, NP);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, ADDR);

      // R7: two cells back to back
      cur_tag = "R7 back to back";
      for (int i = 0; i < 2 * CB; i++) step(1'b1, 1'b0, ADDR);
      step(1'b1, 1'b0, ADDR);
      step(1'b0, 1'b0, ADDR);

      // R7/R8: concurrent write and read streams
      cur_tag = "R7 concurrent";
      for (int i = 0; i < CB; i++) step(1'b0, 1'b1, NP);
      for (int i = 0; i < 3 * CB; i++) step(1'b1, 1'b1, (i % 7 == 0) ? ADDR : NP);
      for (int i = 0; i < 4 * CB && m_cnt > 0; i++) step(1'b1, 1'b0, NP);
      step(1'b0, 1'b0, ADDR);
      step(1'b0, 1'b0, NP);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule